// File: doc/BRIEF.md
# SIMT Lane-Mask Reconvergence Stack

This block is the per-wave control-flow unit of a lock-step SIMD core. It holds the set of lanes that are currently live, a program counter, and a bounded stack of saved (lane mask, resume address) entries. Each cycle the decoder hands it one operation code, a per-lane condition vector (one bit per lane: 1 means the lane's condition value was nonzero), a resume address and an alternate-path address. The block answers with the live-lane mask, the program counter and a per-lane register write enable.

Divergent `if`/`else` regions and loops are walked depth first. A save operation records where the lanes meet again. A narrowing operation drops lanes whose condition is zero, and it unwinds by itself when no lane is left. A two-way branch records the meeting point and the path still to be run. When both paths have lanes, the path with fewer lanes runs first, so the stack needs only about log2 of the wave width entries. A save that does not fit, or a restore from an empty stack, raises a sticky error flag and changes nothing else.

Operation codes on `opCode`: 0 idle, 1 ordinary lane instruction, 2 save, 3 restore, 4 narrow, 5 branch-and-save. Lane i is bit i of every mask.

Top module: `simt_reconv_stack`

## Requirements
- R1: While reset is held low, and on release, `execMask` is all ones, `pc` equals START_PC, both error flags are 0 and the stack is empty.
- R2: With code 1, `laneWrEn` equals `execMask` and `pc` advances by 1. With every other code, `laneWrEn` is all zeros. With code 0, `pc` and the mask hold.
- R3: Code 2 saves (current mask, `reconvAddr`) on the stack, leaves the mask unchanged and advances `pc` by 1.
- R4: Code 3 removes the top entry, loads its mask into `execMask` and loads its address into `pc`.
- R5: Code 4 sets the mask to the old mask AND `laneCond`, so a lane that is already inactive stays inactive, and advances `pc` by 1 when the result is nonzero.
- R6: If the result of code 4 would be all zeros, the top entry is removed at once: its mask becomes `execMask` and its address becomes `pc`.
- R7: Code 5, when both the then lanes (mask AND cond) and the else lanes (mask AND NOT cond) are nonempty and the then lanes are no more than the else lanes: save (mask, `reconvAddr`), then save (else lanes, `elseAddr`), set the mask to the then lanes and advance `pc` by 1.
- R8: Code 5, when both sets are nonempty and the else lanes are fewer: save (mask, `reconvAddr`), then save (then lanes, `pc`+1), set the mask to the else lanes and set `pc` to `elseAddr`.
- R9: Code 5, when only one set is nonempty: save only (mask, `reconvAddr`) and continue on the live path. Then lanes continue at `pc`+1, else lanes continue at `elseAddr`.
- R10: A save (code 2, or code 5 needing one or two free entries) without room sets `ovfFlag`, which then stays set until reset. The mask, `pc` and the stack are left unchanged.
- R11: A restore from an empty stack (code 3, or code 4 reaching all zeros) sets `unfFlag`, which stays set until reset. The mask, `pc` and the stack are left unchanged.
- R12: `execMask` is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 3 | Decoded control operation for this cycle |
| laneCond | input | W | Per-lane condition, 1 = nonzero |
| reconvAddr | input | AW | Meeting-point address to save |
| elseAddr | input | AW | Alternate-path address |
| execMask | output | W | Live-lane mask |
| pc | output | AW | Program counter |
| laneWrEn | output | W | Per-lane register write enable |
| ovfFlag | output | 1 | Sticky stack-full error |
| unfFlag | output | 1 | Sticky stack-empty error |

## Verification
The bench builds the block with its defaults: 8 lanes, a 4-entry stack, 8-bit addresses, start address 0x10 and smaller-path-first ordering on. Four entries can be filled by a few saves, so both error flags, and a two-entry branch save that fails with only one slot free, can be reached quickly. Eight lanes make a one-lane-versus-seven branch in each direction easy, which shows the path ordering. The odd-lane test mask 0xAA and the return to 0xFF can be checked directly.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_ALU    = 3'd1,
    OP_PUSH   = 3'd2,
    OP_POP    = 3'd3,
    OP_SETNZ  = 3'd4,
    OP_BRPUSH = 3'd5
  } ctlOp_e;

  typedef enum logic [1:0] {
    MK_KEEP = 2'd0,
    MK_THEN = 2'd1,
    MK_ELSE = 2'd2,
    MK_TOP  = 2'd3
  } maskSel_e;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC  = 2'd1,
    PC_TOP  = 2'd2,
    PC_ELSE = 2'd3
  } pcSel_e;

  typedef struct packed {
    logic [1:0] pushCnt;
    logic       secondThen;
    logic       popOne;
    maskSel_e   maskSel;
    pcSel_e     pcSel;
    logic       setOvf;
    logic       setUnf;
    logic       wrLanes;
  } ctlStrobe_t;

endpackage

// File: rtl/simt_ctrl.sv
module simt_ctrl
  import simt_pkg::*;
#(
  parameter int W           = 8,
  parameter int DEPTH       = 4,
  parameter bit SMALL_FIRST = 1'b1,
  localparam int DW         = $clog2(DEPTH + 1)
) (
  input  logic [2:0]    opCode,
  input  logic [W-1:0]  thenMask,
  input  logic [W-1:0]  elseMask,
  input  logic [DW-1:0] depth,
  output ctlStrobe_t    st
);

  function automatic int unsigned popCount(input logic [W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  logic thenAny, elseAny, bothAny, elseFirst;
  logic roomOne, roomTwo, stackEmpty;
  ctlOp_e op;

  assign op         = ctlOp_e'(opCode);
  assign thenAny    = |thenMask;
  assign elseAny    = |elseMask;
  assign bothAny    = thenAny && elseAny;
  assign roomOne    = int'(depth) < DEPTH;
  assign roomTwo    = (int'(depth) + 2) <= DEPTH;
  assign stackEmpty = (depth == '0);

  generate
    if (SMALL_FIRST) begin : gSmallFirst
      assign elseFirst = popCount(elseMask) < popCount(thenMask);
    end else begin : gThenFirst
      assign elseFirst = 1'b0;
    end
  endgenerate

  always_comb begin
    st         = '0;
    st.maskSel = MK_KEEP;
    st.pcSel   = PC_HOLD;
    unique case (op)
      OP_ALU: begin
        st.wrLanes = 1'b1;
        st.pcSel   = PC_INC;
      end
      OP_PUSH: begin
        if (roomOne) begin
          st.pushCnt = 2'd1;
          st.pcSel   = PC_INC;
        end else begin
          st.setOvf = 1'b1;
        end
      end
      OP_POP: begin
        if (!stackEmpty) begin
          st.popOne  = 1'b1;
          st.maskSel = MK_TOP;
          st.pcSel   = PC_TOP;
        end else begin
          st.setUnf = 1'b1;
        end
      end
      OP_SETNZ: begin
        if (thenAny) begin
          st.maskSel = MK_THEN;
          st.pcSel   = PC_INC;
        end else if (!stackEmpty) begin
          st.popOne  = 1'b1;
          st.maskSel = MK_TOP;
          st.pcSel   = PC_TOP;
        end else begin
          st.setUnf = 1'b1;
        end
      end
      OP_BRPUSH: begin
        if (bothAny && !roomTwo) begin
          st.setOvf = 1'b1;
        end else if (!roomOne) begin
          st.setOvf = 1'b1;
        end else if (bothAny) begin
          st.pushCnt = 2'd2;
          if (elseFirst) begin
            st.secondThen = 1'b1;
            st.maskSel    = MK_ELSE;
            st.pcSel      = PC_ELSE;
          end else begin
            st.maskSel = MK_THEN;
            st.pcSel   = PC_INC;
          end
        end else if (thenAny) begin
          st.pushCnt = 2'd1;
          st.maskSel = MK_THEN;
          st.pcSel   = PC_INC;
        end else begin
          st.pushCnt = 2'd1;
          st.maskSel = MK_ELSE;
          st.pcSel   = PC_ELSE;
        end
      end
      default: begin
        st.pcSel = PC_HOLD;
      end
    endcase
  end

endmodule

// File: rtl/simt_dpath.sv
module simt_dpath
  import simt_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 8,
  parameter int DEPTH     = 4,
  parameter int START_PC  = 16,
  localparam int DW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  laneCond,
  input  logic [AW-1:0] reconvAddr,
  input  logic [AW-1:0] elseAddr,
  input  ctlStrobe_t    st,
  output logic [W-1:0]  execMask,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] depth,
  output logic [W-1:0]  thenMask,
  output logic [W-1:0]  elseMask,
  output logic [W-1:0]  laneWrEn,
  output logic          ovfFlag,
  output logic          unfFlag
);

  logic [W-1:0]  stkMask [DEPTH];
  logic [AW-1:0] stkAddr [DEPTH];
  logic [W-1:0]  topMask;
  logic [AW-1:0] topAddr;
  logic [DW-1:0] topIdx;
  logic [AW-1:0] pcInc;
  logic [W-1:0]  secMask;
  logic [AW-1:0] secAddr;
  logic [W-1:0]  maskNext;
  logic [AW-1:0] pcNext;
  logic [DW-1:0] depthNext;

  assign thenMask = execMask & laneCond;
  assign elseMask = execMask & ~laneCond;
  assign pcInc    = pc + AW'(1);
  assign topIdx   = (depth == '0) ? '0 : depth - DW'(1);
  assign secMask  = st.secondThen ? thenMask : elseMask;
  assign secAddr  = st.secondThen ? pcInc : elseAddr;
  assign laneWrEn = st.wrLanes ? execMask : '0;

  always_comb begin
    topMask = '0;
    topAddr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (DW'(i) == topIdx) begin
        topMask = stkMask[i];
        topAddr = stkAddr[i];
      end
    end
  end

  always_comb begin
    unique case (st.maskSel)
      MK_THEN: maskNext = thenMask;
      MK_ELSE: maskNext = elseMask;
      MK_TOP:  maskNext = topMask;
      default: maskNext = execMask;
    endcase
    unique case (st.pcSel)
      PC_INC:  pcNext = pcInc;
      PC_TOP:  pcNext = topAddr;
      PC_ELSE: pcNext = elseAddr;
      default: pcNext = pc;
    endcase
    depthNext = depth + DW'(st.pushCnt) - DW'(st.popOne);
  end

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stkMask[gi] <= '0;
          stkAddr[gi] <= '0;
        end else if (st.pushCnt != 2'd0 && DW'(gi) == depth) begin
          stkMask[gi] <= execMask;
          stkAddr[gi] <= reconvAddr;
        end else if (st.pushCnt == 2'd2 && DW'(gi) == depth + DW'(1)) begin
          stkMask[gi] <= secMask;
          stkAddr[gi] <= secAddr;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execMask <= '1;
      pc       <= AW'(START_PC);
      depth    <= '0;
      ovfFlag  <= 1'b0;
      unfFlag  <= 1'b0;
    end else begin
      execMask <= maskNext;
      pc       <= pcNext;
      depth    <= depthNext;
      if (st.setOvf) ovfFlag <= 1'b1;
      if (st.setUnf) unfFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 8,
  parameter int DEPTH       = 4,
  parameter int START_PC    = 16,
  parameter bit SMALL_FIRST = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    opCode,
  input  logic [W-1:0]  laneCond,
  input  logic [AW-1:0] reconvAddr,
  input  logic [AW-1:0] elseAddr,
  output logic [W-1:0]  execMask,
  output logic [AW-1:0] pc,
  output logic [W-1:0]  laneWrEn,
  output logic          ovfFlag,
  output logic          unfFlag
);

  localparam int DW = $clog2(DEPTH + 1);

  ctlStrobe_t    strobe;
  logic [DW-1:0] stkDepth;
  logic [W-1:0]  thenMask;
  logic [W-1:0]  elseMask;

  simt_ctrl #(
    .W(W), .DEPTH(DEPTH), .SMALL_FIRST(SMALL_FIRST)
  ) uCtrl (
    .opCode(opCode), .thenMask(thenMask), .elseMask(elseMask),
    .depth(stkDepth), .st(strobe)
  );

  simt_dpath #(
    .W(W), .AW(AW), .DEPTH(DEPTH), .START_PC(START_PC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .laneCond(laneCond),
    .reconvAddr(reconvAddr), .elseAddr(elseAddr), .st(strobe),
    .execMask(execMask), .pc(pc), .depth(stkDepth),
    .thenMask(thenMask), .elseMask(elseMask), .laneWrEn(laneWrEn),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

endmodule

// File: rtl/simt_reconv_chk.sv
module simt_reconv_chk
  import simt_pkg::*;
#(
  parameter int W     = 8,
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [2:0]    opCode,
  input logic [W-1:0]  laneCond,
  input logic [W-1:0]  execMask,
  input logic [AW-1:0] pc,
  input logic [W-1:0]  laneWrEn,
  input logic          ovfFlag,
  input logic          unfFlag,
  input logic [DW-1:0] stkDepth
);

  AST_WREN_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (laneWrEn & ~execMask) == '0); // R2

  AST_CTRL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (opCode != OP_ALU) |-> (laneWrEn == '0)); // R2

  AST_MASK_NEVER_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    execMask != '0); // R12

  AST_SETNZ_NARROWS: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_SETNZ && (execMask & laneCond) != '0)
      |=> (execMask == $past(execMask & laneCond))); // R5

  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_POP && stkDepth != '0)
      |=> (stkDepth == $past(stkDepth) - DW'(1))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(stkDepth) <= DEPTH); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag); // R10

  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_POP && stkDepth == '0)
      |=> ($stable(execMask) && $stable(pc) && unfFlag)); // R11

endmodule

bind simt_reconv_stack simt_reconv_chk #(
  .W(W), .AW(AW), .DEPTH(DEPTH)
) uChk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .laneCond(laneCond),
  .execMask(execMask), .pc(pc), .laneWrEn(laneWrEn),
  .ovfFlag(ovfFlag), .unfFlag(unfFlag), .stkDepth(stkDepth)
);

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;

  localparam int W = 8, AW = 8, DEPTH = 4, START_PC = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    opCode = 3'd0;
  logic [W-1:0]  laneCond = '0;
  logic [AW-1:0] reconvAddr = '0;
  logic [AW-1:0] elseAddr = '0;
  logic [W-1:0]  execMask;
  logic [AW-1:0] pc;
  logic [W-1:0]  laneWrEn;
  logic          ovfFlag, unfFlag;

  simt_reconv_stack #(.W(W), .AW(AW), .DEPTH(DEPTH), .START_PC(START_PC)) uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .laneCond(laneCond),
    .reconvAddr(reconvAddr), .elseAddr(elseAddr), .execMask(execMask),
    .pc(pc), .laneWrEn(laneWrEn), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0]  wr;
    logic [W-1:0]  mask;
    logic [AW-1:0] pc;
    logic          ovf;
    logic          unf;
    string         tag;
  } expItem_t;

  expItem_t scq[$];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [W-1:0]  mMask;
  logic [AW-1:0] mPc;
  logic          mOvf, mUnf;
  logic [W-1:0]  sMask [DEPTH];
  logic [AW-1:0] sAddr [DEPTH];
  int            mDepth;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int cnt(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic mPush(input logic [W-1:0] m, input logic [AW-1:0] a);
    sMask[mDepth] = m;
    sAddr[mDepth] = a;
    mDepth++;
  endtask

  task automatic mPop();
    mDepth--;
    mMask = sMask[mDepth];
    mPc   = sAddr[mDepth];
  endtask

  // Driver: applies one operation, predicts the result from the requirements.
  task automatic issue(input logic [2:0] op, input logic [W-1:0] cond,
                       input logic [AW-1:0] ra, input logic [AW-1:0] ea, input string tag);
    expItem_t it;
    logic [W-1:0] tM, eM;
    opCode = op; laneCond = cond; reconvAddr = ra; elseAddr = ea;
    it.wr = (op == 3'd1) ? mMask : '0;
    tM = mMask & cond;
    eM = mMask & ~cond;
    case (op)
      3'd1: mPc = mPc + 1'b1;
      3'd2: if (mDepth < DEPTH) begin mPush(mMask, ra); mPc = mPc + 1'b1; end
            else mOvf = 1'b1;
      3'd3: if (mDepth > 0) mPop(); else mUnf = 1'b1;
      3'd4: if (tM != '0) begin mMask = tM; mPc = mPc + 1'b1; end
            else if (mDepth > 0) mPop();
            else mUnf = 1'b1;
      3'd5: begin
        if ((tM != '0 && eM != '0 && mDepth + 2 > DEPTH) || mDepth + 1 > DEPTH) mOvf = 1'b1;
        else if (tM != '0 && eM != '0) begin
          mPush(mMask, ra);
          if (cnt(eM) < cnt(tM)) begin
            mPush(tM, mPc + 1'b1); mMask = eM; mPc = ea;
          end else begin
            mPush(eM, ea); mMask = tM; mPc = mPc + 1'b1;
          end
        end else if (tM != '0) begin
          mPush(mMask, ra); mMask = tM; mPc = mPc + 1'b1;
        end else begin
          mPush(mMask, ra); mMask = eM; mPc = ea;
        end
      end
      default: ;
    endcase
    it.mask = mMask; it.pc = mPc; it.ovf = mOvf; it.unf = mUnf; it.tag = tag;
    scq.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: samples write enable before the edge, state after it.
  initial begin
    expItem_t it;
    logic [W-1:0] wrSeen;
    forever begin
      @(negedge clk);
      #2;
      if (scq.size() > 0) begin
        it = scq.pop_front();
        wrSeen = laneWrEn;
        @(posedge clk);
        #1;
        chk(it.tag, "laneWrEn", 32'(wrSeen), 32'(it.wr));
        chk(it.tag, "execMask", 32'(execMask), 32'(it.mask));
        chk(it.tag, "pc", 32'(pc), 32'(it.pc));
        chk(it.tag, "ovfFlag", 32'(ovfFlag), 32'(it.ovf));
        chk(it.tag, "unfFlag", 32'(unfFlag), 32'(it.unf));
        chk("R12", "mask nonzero", 32'(execMask != '0), 32'd1);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mMask = '1; mPc = AW'(START_PC); mOvf = 0; mUnf = 0; mDepth = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset mask", 32'(execMask), 32'hFF);
    chk("R1", "reset pc", 32'(pc), 32'(START_PC));
    chk("R1", "reset flags", {30'b0, ovfFlag, unfFlag}, 32'd0);
    rstN = 1'b1;
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R2");
    issue(3'd0, 8'h00, 8'h00, 8'h00, "R2");
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R2");
    // Odd-lane test region: mask 0xAA then back to 0xFF.
    issue(3'd2, 8'h00, 8'h40, 8'h00, "R3");
    issue(3'd4, 8'hAA, 8'h00, 8'h00, "R5");
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R2");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R4");
    // Nested narrowing and the automatic restore.
    issue(3'd2, 8'h00, 8'h60, 8'h00, "R3");
    issue(3'd4, 8'h0F, 8'h00, 8'h00, "R5");
    issue(3'd4, 8'h3C, 8'h00, 8'h00, "R5");
    issue(3'd4, 8'hF0, 8'h00, 8'h00, "R6");
    // Loop-style narrowing: lanes leave one by one.
    issue(3'd2, 8'h00, 8'h70, 8'h00, "R3");
    issue(3'd4, 8'h07, 8'h00, 8'h00, "R5");
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R2");
    issue(3'd4, 8'h03, 8'h00, 8'h00, "R5");
    issue(3'd4, 8'h00, 8'h00, 8'h00, "R6");
    // Two-way branch, then side smaller.
    issue(3'd5, 8'h01, 8'h80, 8'h90, "R7");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R7");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R7");
    // Two-way branch, else side smaller.
    issue(3'd5, 8'hFE, 8'hA0, 8'hB0, "R8");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R8");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R8");
    // Single-path branches.
    issue(3'd5, 8'hFF, 8'hC0, 8'hD0, "R9");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R9");
    issue(3'd5, 8'h00, 8'hC4, 8'hD4, "R9");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R9");
    // Fill the stack and overflow.
    issue(3'd2, 8'h00, 8'h21, 8'h00, "R3");
    issue(3'd2, 8'h00, 8'h22, 8'h00, "R3");
    issue(3'd2, 8'h00, 8'h23, 8'h00, "R3");
    issue(3'd5, 8'h0F, 8'h24, 8'h25, "R10");
    issue(3'd2, 8'h00, 8'h26, 8'h00, "R3");
    issue(3'd2, 8'h00, 8'h27, 8'h00, "R10");
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R10");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R10");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R4");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R4");
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R4");
    // Empty stack restores.
    issue(3'd3, 8'h00, 8'h00, 8'h00, "R11");
    issue(3'd4, 8'h00, 8'h00, 8'h00, "R11");
    issue(3'd1, 8'h00, 8'h00, 8'h00, "R11");
    opCode = 3'd0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule